// File: doc/BRIEF.md
# Power-Good Reset Timer with Margin Hold

This block produces an active-high power-good signal, used as a reset release, for a group of sequenced supply rails. It takes digital flags from comparators elsewhere in the chip. Each channel has a flag that is high while that channel's output is above the power-good fraction of its input. One flag reports that every undervoltage-threshold input is good. Another reports that the enable input is above its rising threshold. The block also takes an active-low margin input and a programmable extension of the timeout.

The output rises only after every active channel, the threshold flag and the enable flag have all been good together for an unbroken timeout. The timeout is a fixed base count plus the programmed extension. A channel can be excluded, and it then plays no part in the decision. Any bad condition pulls the output low at the next clock and restarts the timer.

While margin is held low, monitoring stops and the output keeps whatever state it had. This lets the system test its rails away from their nominal levels. When margin returns high, normal monitoring resumes. The comparator hysteresis and the open-drain drive are outside the block.

Top module: `pgt_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, `pg_out` is low.
- R2: With margin high, the timeout count is T = BASE_CYCLES + `ext_cycles`. Suppose the good condition is first sampled at a rising edge while `pg_out` is low. If it stays good at T consecutive rising edges, `pg_out` goes high after the T-th edge and not before.
- R3: With `ext_cycles` = 0, the timeout is exactly BASE_CYCLES cycles. This is the default minimum timeout.
- R4: A channel whose `ch_skip` bit is 1 is ignored. The good condition is: the AND over all channels of (`ch_good[i]` OR `ch_skip[i]`), AND `thr_ok`, AND `en_ok`.
- R5: With margin high, an edge that samples `thr_ok` low leaves `pg_out` low after that edge.
- R6: With margin high, an edge that samples `en_ok` low leaves `pg_out` low after that edge.
- R7: With margin high, an edge that samples any active channel's `ch_good` low leaves `pg_out` low after that edge.
- R8: If the good condition is lost at even one edge while the timeout is running, the count clears. The full T edges of good condition are then needed again.
- R9: While `margin_n` is low, a high `pg_out` stays high whatever the other inputs do.
- R10: While `margin_n` is low, a low `pg_out` stays low whatever the other inputs do. No timeout progress is made, so after release a full T edges are needed.
- R11: After `margin_n` returns high, monitoring resumes. A bad condition drops `pg_out` at the next edge, and a good one raises it after T edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ch_good | input | NUM_CH | Per-channel flag: output above the power-good fraction of its input |
| ch_skip | input | NUM_CH | Per-channel exclusion: 1 removes the channel from the decision |
| thr_ok | input | 1 | All undervoltage-threshold inputs are above their levels |
| en_ok | input | 1 | Enable input is above its rising threshold |
| margin_n | input | 1 | Margin request, active low: freezes the output and suspends monitoring |
| ext_cycles | input | CNT_W | Programmable extension added to the base timeout count |
| pg_out | output | 1 | Power-good / reset release, active high |

## Verification
The assertions take for granted that `ext_cycles` does not change while a timeout is being counted. The timing property computes the expected count from its value at the moment of the rise. They also assume that the flags are clean, synchronous levels that are already debounced and have hysteresis applied. The stimulus follows this in every phase. `ext_cycles` is changed only while the threshold flag is held low, which keeps the timer cleared. Every input is driven one nanosecond after a rising edge, so each flag is a stable level at the next edge.

// File: rtl/pgt_pkg.sv
package pgt_pkg;
    // Operating mode decoded each cycle by the top module.
    typedef enum logic [1:0] {
        MODE_FROZEN = 2'd0,  // margin low: hold output, suspend timing
        MODE_FAULT  = 2'd1,  // condition bad: force output low
        MODE_TIMING = 2'd2,  // condition good, output still low
        MODE_GOOD   = 2'd3   // condition good, output already high
    } pgt_mode_e;
endpackage

// File: rtl/pgt_qualify.sv
// Combines per-channel good flags with exclusion bits and the shared
// threshold/enable flags into one "all good" level.
// Assumes all inputs are synchronous levels already debounced upstream.
module pgt_qualify #(
    parameter int NUM_CH = 3
) (
    input  logic [NUM_CH-1:0] ch_good,
    input  logic [NUM_CH-1:0] ch_skip,
    input  logic              thr_ok,
    input  logic              en_ok,
    output logic              all_ok
);
    logic [NUM_CH-1:0] ch_ok;

    // Per-channel acceptance: good, or excluded from the decision.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign ch_ok[i] = ch_good[i] | ch_skip[i];
    end

    // Overall condition: every channel accepted plus shared flags.
    assign all_ok = (&ch_ok) & thr_ok & en_ok;
endmodule

// File: rtl/pgt_timer.sv
// Counts consecutive run cycles and flags the cycle in which the count
// reaches BASE_CYCLES + ext_cycles. Clears whenever run is low.
// Assumes BASE_CYCLES >= 1 and ext_cycles steady while running.
module pgt_timer #(
    parameter int CNT_W       = 16,
    parameter int BASE_CYCLES = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] ext_cycles,
    output logic             done
);
    localparam int LIM_W = $clog2(BASE_CYCLES + (2 ** CNT_W)) + 1;

    logic [LIM_W-1:0] cnt;
    logic [LIM_W-1:0] limit;

    // Total period: fixed base plus programmed extension.
    assign limit = LIM_W'(BASE_CYCLES) + {{(LIM_W-CNT_W){1'b0}}, ext_cycles};

    // Terminal flag; >= keeps it safe if the limit shrinks mid-count.
    assign done = run && (cnt >= limit - LIM_W'(1));

    // Consecutive-cycle counter, cleared on any interruption.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || done) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + LIM_W'(1);
        end
    end
endmodule

// File: rtl/pgt_top.sv
// Power-good reset timer: raises pg_out once every active channel and the
// shared flags have been good for an unbroken timeout, drops it on the
// next edge after any bad condition, and freezes it while margin_n is low.
// Assumes synchronous, debounced input flags.
module pgt_top
    import pgt_pkg::*;
#(
    parameter int NUM_CH      = 3,
    parameter int CNT_W       = 16,
    parameter int BASE_CYCLES = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_good,
    input  logic [NUM_CH-1:0] ch_skip,
    input  logic              thr_ok,
    input  logic              en_ok,
    input  logic              margin_n,
    input  logic [CNT_W-1:0]  ext_cycles,
    output logic              pg_out
);
    logic      all_ok;
    logic      tmr_done;
    logic      pg_q;
    pgt_mode_e mode;

    pgt_qualify #(.NUM_CH(NUM_CH)) u_qual (
        .ch_good (ch_good),
        .ch_skip (ch_skip),
        .thr_ok  (thr_ok),
        .en_ok   (en_ok),
        .all_ok  (all_ok)
    );

    // Mode decode: margin has priority, then faults, then timing state.
    always_comb begin
        if (!margin_n)    mode = MODE_FROZEN;
        else if (!all_ok) mode = MODE_FAULT;
        else if (pg_q)    mode = MODE_GOOD;
        else              mode = MODE_TIMING;
    end

    pgt_timer #(.CNT_W(CNT_W), .BASE_CYCLES(BASE_CYCLES)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (mode == MODE_TIMING),
        .ext_cycles (ext_cycles),
        .done       (tmr_done)
    );

    // Output register: clear on fault, set on timeout, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pg_q <= 1'b0;
        end else begin
            case (mode)
                MODE_FAULT:  pg_q <= 1'b0;
                MODE_TIMING: if (tmr_done) pg_q <= 1'b1;
                default:     pg_q <= pg_q;
            endcase
        end
    end

    assign pg_out = pg_q;
endmodule

// File: rtl/pgt_checker.sv
// Property checker for pgt_top, attached by bind. Models the consecutive
// good-cycle count independently to check the rise timing.
module pgt_checker #(
    parameter int NUM_CH      = 3,
    parameter int CNT_W       = 16,
    parameter int BASE_CYCLES = 200
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] ch_good,
    input logic [NUM_CH-1:0] ch_skip,
    input logic              thr_ok,
    input logic              en_ok,
    input logic              margin_n,
    input logic [CNT_W-1:0]  ext_cycles,
    input logic              pg_out
);
    localparam int LIM_W = $clog2(BASE_CYCLES + (2 ** CNT_W)) + 1;

    logic             chans_ok;
    logic [LIM_W-1:0] run_cnt;

    assign chans_ok = &(ch_good | ch_skip);

    // Count of consecutive edges with margin high, all good, output low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (margin_n && chans_ok && thr_ok && en_ok && !pg_out) begin
            run_cnt <= run_cnt + LIM_W'(1);
        end else begin
            run_cnt <= '0;
        end
    end

    // R2 / R3 / R8: rise only after exactly the full unbroken period.
    p_rise_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pg_out) |-> ($past(run_cnt) + LIM_W'(1) ==
            LIM_W'(BASE_CYCLES) + {{(LIM_W-CNT_W){1'b0}}, $past(ext_cycles)}));

    // R4: a rise needs every non-excluded channel good at the deciding edge.
    p_rise_needs_ch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pg_out) |-> $past(margin_n && chans_ok));

    p_thr_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (margin_n && !thr_ok) |=> !pg_out);

    p_en_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (margin_n && !en_ok) |=> !pg_out);

    p_ch_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (margin_n && !chans_ok) |=> !pg_out);

    // R9 and R10: output frozen while margin is low.
    p_margin_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !margin_n |=> $stable(pg_out));
endmodule

bind pgt_top pgt_checker #(
    .NUM_CH      (NUM_CH),
    .CNT_W       (CNT_W),
    .BASE_CYCLES (BASE_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ch_good    (ch_good),
    .ch_skip    (ch_skip),
    .thr_ok     (thr_ok),
    .en_ok      (en_ok),
    .margin_n   (margin_n),
    .ext_cycles (ext_cycles),
    .pg_out     (pg_out)
);

// File: tb/sim_pgt_top.sv
module sim_pgt_top;
    localparam int N    = 3;
    localparam int CW   = 3;
    localparam int BASE = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  ch_good, ch_skip;
    logic          thr_ok, en_ok, margin_n;
    logic [CW-1:0] ext_cycles;
    logic          pg_out;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    always #10 clk = ~clk;

    pgt_top #(.NUM_CH(N), .CNT_W(CW), .BASE_CYCLES(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .ch_good(ch_good), .ch_skip(ch_skip),
        .thr_ok(thr_ok), .en_ok(en_ok), .margin_n(margin_n),
        .ext_cycles(ext_cycles), .pg_out(pg_out)
    );

    task automatic chk(string req, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic chk_int(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic all_good();
        ch_good = '1; ch_skip = '0; thr_ok = 1'b1; en_ok = 1'b1; margin_n = 1'b1;
    endtask

    // Clear the timer with one bad edge, restore, count edges to the rise.
    task automatic measure(output int cyc);
        thr_ok = 1'b0;
        tick(1);
        thr_ok = 1'b1;
        cyc = 0;
        for (int k = 0; k < 40; k++) begin
            tick(1);
            cyc++;
            if (pg_out) break;
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!ended) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int cyc;
        int t;
        rst_n = 1'b0;
        all_good();
        ext_cycles = '0;
        tick(4);
        chk("R1 low in reset", pg_out, 1'b0);
        rst_n = 1'b1;
        tick(1);
        chk("R1 low first cycle after reset", pg_out, 1'b0);

        // R3: default minimum timeout.
        measure(cyc);
        chk_int("R3 base timeout with ext=0", cyc, BASE);

        // R2: sweep every extension value.
        for (int e = 0; e < (1 << CW); e++) begin
            thr_ok = 1'b0;
            ext_cycles = CW'(e);
            measure(cyc);
            chk_int("R2 timeout = base + ext", cyc, BASE + e);
        end

        // R4: all good/skip combinations.
        ext_cycles = CW'(1);
        t = BASE + 1;
        for (int c = 0; c < (1 << (2 * N)); c++) begin
            thr_ok = 1'b0;
            tick(1);
            ch_good = N'(c);
            ch_skip = N'(c >> N);
            thr_ok = 1'b1;
            tick(t + 2);
            chk("R4 exclusion combination", pg_out,
                &(ch_good | ch_skip));
        end

        // R5: threshold drop.
        all_good();
        tick(t + 2);
        chk("R5 precondition high", pg_out, 1'b1);
        thr_ok = 1'b0;
        tick(1);
        chk("R5 thr drop", pg_out, 1'b0);

        // R6: enable drop.
        all_good();
        tick(t + 2);
        en_ok = 1'b0;
        tick(1);
        chk("R6 en drop", pg_out, 1'b0);

        // R7: active channel drop while high, and skipped channel drop ignored.
        all_good();
        ch_skip = 3'b100;
        tick(t + 2);
        ch_good = 3'b011;
        tick(2);
        chk("R7 skipped channel drop ignored", pg_out, 1'b1);
        ch_good = 3'b101;
        tick(1);
        chk("R7 active channel drop", pg_out, 1'b0);

        // R8: interruption restarts the full count.
        all_good();
        thr_ok = 1'b0;
        ext_cycles = CW'(3);
        t = BASE + 3;
        tick(1);
        thr_ok = 1'b1;
        tick(t - 1);
        ch_good[1] = 1'b0;
        tick(1);
        ch_good[1] = 1'b1;
        tick(t - 1);
        chk("R8 still low one edge before full restart", pg_out, 1'b0);
        tick(1);
        chk("R8 high after full restart", pg_out, 1'b1);

        // R9: margin freezes a high output against faults.
        margin_n = 1'b0;
        tick(1);
        thr_ok = 1'b0;
        en_ok = 1'b0;
        ch_good = '0;
        tick(5);
        chk("R9 high held under margin", pg_out, 1'b1);

        // R11: release with bad condition drops next edge.
        margin_n = 1'b1;
        tick(1);
        chk("R11 drop after release", pg_out, 1'b0);

        // R10: margin freezes a low output against good condition.
        margin_n = 1'b0;
        tick(1);
        thr_ok = 1'b1; en_ok = 1'b1; ch_good = '1;
        tick(3 * t);
        chk("R10 low held under margin", pg_out, 1'b0);

        // R11: release with good condition rises after a full T.
        margin_n = 1'b1;
        tick(t - 1);
        chk("R11 low one edge before T after release", pg_out, 1'b0);
        tick(1);
        chk("R11 high T edges after release", pg_out, 1'b1);

        ended = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule